// File: doc/BRIEF.md
# Vectored Level Interrupt Controller

This block gathers sixteen level-sensitive interrupt request lines from local peripherals and merges them into a single interrupt line towards the processor. A 16-bit enable mask decides which request lines may take part. Software reads one byte to learn which source to service. That byte is not a bitmap. It is the index of the most urgent enabled source, plus one, multiplied by four, so it can be used directly as an offset into a jump table.

The register port is byte-wide, with one address, a write strobe, a read strobe and 8-bit data in each direction. A host that issues 16-bit or 32-bit transfers splits them into byte transfers, least significant byte at the lowest offset. There are no handshakes on this port. Every strobe is accepted in the cycle it is seen, and read data appears one clock later. The request lines are assumed synchronous to the block clock. The block samples them every cycle and keeps no memory of past levels.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Request lines are level-sensitive. A source counts as active only while its line is high, and a line that drops clears that source with no latched history.
- R2: `irq_o` is registered. A request line that goes high before clock edge t is sampled at t, and with its enable bit set `irq_o` is high after edge t+1. `irq_o` is high exactly when an active source is enabled.
- R3: A read at offset 0 returns `(n + 1) * 4`, where n is the lowest-numbered source that is both active and enabled. Source 0 is the most urgent. The read returns 0 when no such source exists.
- R4: Enable bits 7..0 are written by a byte write at offset 2, and enable bits 15..8 by a byte write at offset 3. Each write leaves the other byte unchanged.
- R5: A source whose enable bit is 0 has no effect on `irq_o` or on the offset-0 value, even while its line is high.
- R6: A 16-bit enable value written as two byte writes takes full effect whichever of the two bytes is written first.
- R7: Reads at any offset other than 0 return 0, and this includes offsets 2 and 3, so the mask cannot be read back. Writes to any offset other than 2 or 3 change nothing.
- R8: An active-low asynchronous reset clears the enable mask and the sampled sources, and drives `irq_o` and `rdata_o` to 0 at once.
- R9: `rdata_o` carries the read result in the cycle after the read strobe, and is 0 in any cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Level-sensitive interrupt request lines |
| addr_i | input | 12 | Byte offset of the register access |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data byte, valid one clock after `rd_en_i` |
| irq_o | output | 1 | Combined interrupt to the processor |

## Verification
The hardest case to reach is two sources that are active in the same sampled cycle. Only then does the priority choice show, and the answer must also survive partial masking. The stimulus visits every one of the 120 unordered pairs of sources with the full mask enabled. It raises both lines in one cycle, lets them be sampled, and then reads the vector. A second sweep clears the enable bit of the lower source in each pair, so the vector must name the higher one. Byte-ordered mask writes and an asynchronous reset applied while sources are active and enabled finish the picture.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/irqc_src_reg.sv
// Samples the level request lines once per clock; nothing is held beyond one cycle.
module irqc_src_reg #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] src_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_o <= '0;
    else        src_o <= req_i;
  end
endmodule

// File: rtl/irqc_mask_bank.sv
// Enable mask built from byte lanes, each lane written at its own offset.
module irqc_mask_bank
  import irqc_pkg::*;
#(
  parameter int N      = 16,
  parameter int ADDR_W = 12,
  parameter int BASE   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  byte_t             wdata_i,
  output logic [N-1:0]      mask_o
);
  localparam int LANES = N / BYTE_W;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic hit;
    assign hit = wr_en_i && (addr_i == ADDR_W'(BASE + b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mask_o[b*BYTE_W +: BYTE_W] <= '0;
      else if (hit) mask_o[b*BYTE_W +: BYTE_W] <= wdata_i;
    end
  end
endmodule

// File: rtl/irqc_prio_enc.sv
// Lowest set index wins; output is the scaled dispatch value, 0 if none.
module irqc_prio_enc
  import irqc_pkg::*;
#(
  parameter int N     = 16,
  parameter int SHIFT = 2
) (
  input  logic [N-1:0] pend_i,
  output byte_t        vec_o
);
  always_comb begin
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) vec_o = byte_t'((i + 1) << SHIFT);
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC    = 16,
  parameter int ADDR_W     = 12,
  parameter int VEC_OFFSET = 0,
  parameter int MASK_BASE  = 2,
  parameter int VEC_SHIFT  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pend;
  byte_t              vec;
  logic               vec_rd;
  logic               irq_q;
  byte_t              rdata_q;

  irqc_src_reg #(.N(NUM_SRC)) src_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .src_o(src_q)
  );

  irqc_mask_bank #(.N(NUM_SRC), .ADDR_W(ADDR_W), .BASE(MASK_BASE)) mask_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .mask_o(mask_q)
  );

  assign pend = src_q & mask_q;

  irqc_prio_enc #(.N(NUM_SRC), .SHIFT(VEC_SHIFT)) enc_i (
    .pend_i(pend), .vec_o(vec)
  );

  assign vec_rd = rd_en_i && (addr_i == ADDR_W'(VEC_OFFSET));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      irq_q   <= |pend;
      rdata_q <= vec_rd ? vec : '0;
    end
  end

  assign irq_o   = irq_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int N          = 16,
  parameter int ADDR_W     = 12,
  parameter int VEC_OFFSET = 0,
  parameter int MASK_BASE  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      req_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              irq_o,
  input logic [N-1:0]      src_q,
  input logic [N-1:0]      mask_q
);
  AST_SRC_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> src_q == $past(req_i)); // R1

  AST_IRQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q & mask_q) != '0 |=> irq_o); // R2

  AST_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q & mask_q) == '0 |=> !irq_o); // R5

  AST_VEC_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == ADDR_W'(VEC_OFFSET) && (src_q & mask_q) == '0) |=> rdata_o == 8'h00); // R3

  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == ADDR_W'(VEC_OFFSET) && (src_q & mask_q) != '0)
      |=> (rdata_o[1:0] == 2'b00 && rdata_o != 8'h00)); // R3

  AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i != ADDR_W'(VEC_OFFSET)) |=> rdata_o == 8'h00); // R7

  AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> rdata_o == 8'h00); // R9

  AST_MASK_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(MASK_BASE))
      |=> (mask_q[7:0] == $past(wdata_i) && mask_q[15:8] == $past(mask_q[15:8]))); // R4

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && (addr_i == ADDR_W'(MASK_BASE) || addr_i == ADDR_W'(MASK_BASE + 1)))
      |=> $stable(mask_q)); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (mask_q == '0 && !irq_o && rdata_o == 8'h00)); // R8
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(
  .N(NUM_SRC), .ADDR_W(ADDR_W), .VEC_OFFSET(VEC_OFFSET), .MASK_BASE(MASK_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .src_q(src_q), .mask_q(mask_q)
);

// File: tb/vec_irq_ctrl_tb_top.sv
module vec_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC       = 16;
  localparam int WD_LIMIT   = 100000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b1;
  logic [NSRC-1:0] req = '0;
  logic [11:0]     addr = '0;
  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic [7:0]      wdata = '0;
  logic [7:0]      rdata;
  logic            irq;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  vec_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [NSRC-1:0] m_src, m_mask;
  logic            m_irq;
  int              m_rdata;

  function automatic int vec_of(input logic [NSRC-1:0] p);
    for (int k = 0; k < NSRC; k++) if (p[k]) return (k + 1) * 4;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_src = '0; m_mask = '0; m_irq = 0; m_rdata = 0;
    end else begin
      logic [NSRC-1:0] p;
      p = m_src & m_mask;
      m_irq   = (p != '0);
      m_rdata = (rd_en && addr == 12'd0) ? vec_of(p) : 0;
      if (wr_en && addr == 12'd2) m_mask[7:0]  = wdata;
      if (wr_en && addr == 12'd3) m_mask[15:8] = wdata;
      m_src = req;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (irq !== m_irq) begin
        bad++;
        $display("FAIL R2 model irq actual=%0b expected=%0b", irq, m_irq);
      end
      total++;
      if (int'(rdata) != m_rdata || $isunknown(rdata)) begin
        bad++;
        $display("FAIL R3 model rdata actual=%0d expected=%0d", rdata, m_rdata);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R9 watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    addr = 12'(a); wdata = 8'(d); wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(posedge clk); #1;
    addr = 12'(a); rd_en = 1;
    @(posedge clk); #1;
    rd_en = 0;
    v = int'(rdata);
  endtask

  initial begin
    int v;
    #1 rst_n = 0;
    tick(3);
    // R8 reset state
    chk("R8 irq after reset", int'(irq), 0);
    chk("R8 rdata after reset", int'(rdata), 0);
    rst_n = 1;
    rd(0, v); chk("R8 vector after reset", v, 0);

    // R5 all requests active, mask cleared
    req = '1; tick(3);
    chk("R5 irq masked", int'(irq), 0);
    rd(0, v); chk("R5 vector masked", v, 0);

    // R2 / R3 low byte enabled
    wr(2, 8'hFF); tick(2);
    chk("R2 irq enabled", int'(irq), 1);
    rd(0, v); chk("R3 vector source0", v, 4);
    @(posedge clk); #1;
    chk("R9 rdata returns to zero", int'(rdata), 0);

    // R4 byte lanes independent
    wr(3, 8'hFF); wr(2, 8'h00); tick(1);
    rd(0, v); chk("R4 high lane only", v, 36);
    req = 16'h0200; wr(2, 8'h01); tick(1);
    rd(0, v); chk("R4 high byte kept", v, 40);

    // R6 order of byte writes
    wr(2, 0); wr(3, 0);
    wr(3, 8'h80); wr(2, 8'h01);
    req = 16'h8000; tick(2);
    rd(0, v); chk("R6 high then low, src15", v, 64);
    req = 16'h8001; tick(2);
    rd(0, v); chk("R6 high then low, src0", v, 4);

    // R7 other offsets
    wr(2, 8'hFF); wr(3, 8'hFF); tick(1);
    rd(1, v); chk("R7 read offset1", v, 0);
    rd(2, v); chk("R7 mask not readable lo", v, 0);
    rd(3, v); chk("R7 mask not readable hi", v, 0);
    rd(4, v); chk("R7 read offset4", v, 0);
    rd(12'hFFF, v); chk("R7 read top offset", v, 0);
    wr(1, 0); wr(4, 0); wr(12'h802, 0); tick(2);
    chk("R7 ignored writes irq", int'(irq), 1);
    rd(0, v); chk("R7 ignored writes vector", v, 4);

    // R1 level, no latching
    req = 16'h0020; tick(2);
    rd(0, v); chk("R1 level seen", v, 24);
    req = '0; tick(2);
    rd(0, v); chk("R1 dropped no latch", v, 0);
    chk("R1 irq dropped", int'(irq), 0);

    // R2 latency
    req = 16'h0008;
    @(posedge clk); #1;
    chk("R2 irq not yet", int'(irq), 0);
    @(posedge clk); #1;
    chk("R2 irq after two edges", int'(irq), 1);
    req = '0; tick(3);

    // R3 every pair
    for (int i = 0; i < NSRC; i++) begin
      for (int j = i + 1; j < NSRC; j++) begin
        req = (16'd1 << i) | (16'd1 << j);
        tick(1);
        rd(0, v); chk($sformatf("R3 pair %0d,%0d", i, j), v, (i + 1) * 4);
      end
    end

    // R5 lower of pair disabled
    for (int i = 0; i < NSRC; i++) begin
      for (int j = i + 1; j < NSRC; j++) begin
        logic [15:0] mk;
        mk = ~(16'd1 << i);
        wr(2, mk[7:0]); wr(3, mk[15:8]);
        req = (16'd1 << i) | (16'd1 << j);
        tick(1);
        rd(0, v); chk($sformatf("R5 masked pair %0d,%0d", i, j), v, (j + 1) * 4);
      end
    end

    // R8 asynchronous reset mid-run
    wr(2, 8'hFF); wr(3, 8'hFF); req = '1; tick(3);
    chk("R8 irq before reset", int'(irq), 1);
    #2 rst_n = 0;
    #1 chk("R8 irq cleared async", int'(irq), 0);
    tick(1);
    rst_n = 1; tick(2);
    rd(0, v); chk("R8 mask cleared", v, 0);
    chk("R8 irq stays low", int'(irq), 0);

    req = '0; tick(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule